// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block shifts or rotates an operand of 8 or 32 bits by a count from 0 to 31. It supports five operations: logical right shift, arithmetic right shift, left shift (also issued under a second opcode), rotate left and rotate right. It returns the shifted result together with updated zero, sign and carry flags. The count comes either from a count-register input or from an immediate input, and only its low five bits are used. If the masked count is zero, the operand and all three incoming flags pass through unchanged.

Carry holds the last bit that left the word. For right shifts and right rotates that bit leaves at the low end. For left shifts and left rotates it leaves at the top end. In byte mode the unit works only on bits 7:0: rotates wrap inside the byte, zero and sign come from the byte result, and bits 31:8 of the operand pass through unchanged.

The unit takes one request per cycle through `in_valid`. Each request gives a registered response one clock later, with `out_valid` set.

Top module: `shift_rotate_unit`

## Requirements
- R1: The count is `cnt_imm` when `cnt_sel`=1 and `cnt_reg` when `cnt_sel`=0. Only bits 4:0 of the chosen input are used.
- R2: Opcode 0 (logical right) fills vacated bits with 0. Opcode 1 (arithmetic right) fills them with the operand's top bit (bit 31 in word mode, bit 7 in byte mode).
- R3: Opcode 2 and opcode 5 (left shifts) give identical results and flags. Vacated low bits are 0.
- R4: Opcode 3 (rotate left) and opcode 4 (rotate right) wrap within the selected width. In byte mode the rotate amount is the count modulo 8.
- R5: For opcodes 0, 1 and 4, carry is the last bit leaving the low end. With count 1 this is operand bit 0. For shifts that run past the width, carry is the fill bit.
- R6: For opcodes 2, 3 and 5, carry is the last bit leaving the top end. With count 1 this is the operand's top bit. For shifts past the width, carry is 0.
- R7: Zero is 1 when the result of the selected width is all zeros. Sign equals the top bit of the result of the selected width.
- R8: When `wide`=0, result bits 31:8 equal operand bits 31:8.
- R9: A masked count of 0 returns the operand unchanged and copies `zf_in`, `sf_in` and `cf_in` to the flag outputs.
- R10: Opcodes 6 and 7 behave as a count of 0: operand and flags pass through.
- R11: A request accepted with `in_valid`=1 appears on the outputs one clock later with `out_valid`=1. Cycles without `in_valid` leave the result and flags holding their values.
- R12: Synchronous active-low reset clears the result, the flags and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (0 shr, 1 sar, 2 shl, 3 rol, 4 ror, 5 sal) |
| wide | input | 1 | 1 = 32-bit operand, 0 = 8-bit operand |
| operand | input | 32 | Value to shift |
| cnt_sel | input | 1 | 1 = immediate count, 0 = register count |
| cnt_reg | input | 8 | Count from a register |
| cnt_imm | input | 8 | Count from an immediate |
| zf_in | input | 1 | Incoming zero flag |
| sf_in | input | 1 | Incoming sign flag |
| cf_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Response strobe |
| result | output | 32 | Shifted or rotated value |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| cf | output | 1 | Carry flag |

## Verification
The result, the three flags and `out_valid` all come from one register stage, so each is due exactly one rising edge after the edge that samples the request. The bench drives a request just after a falling edge and compares all outputs at the next falling edge, half a period after that register updates. Idle cycles are checked the same way: the bench changes the inputs while `in_valid` is low and confirms that the outputs did not move.

// File: rtl/srl_pkg.sv
// Package: shared opcodes and widths for the shift/rotate unit.
// Assumes: opcodes 6 and 7 are unused and treated as no-operation.
package srl_pkg;
    typedef enum logic [2:0] {
        OP_SHR = 3'd0,
        OP_SAR = 3'd1,
        OP_SHL = 3'd2,
        OP_ROL = 3'd3,
        OP_ROR = 3'd4,
        OP_SAL = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } srl_op_e;

    localparam int SRL_CNT_W = 5;
endpackage

// File: rtl/srl_count_sel.sv
// Module: srl_count_sel
// Picks the count source and keeps only the low CNT_W bits.
// Assumes: SEL_W >= CNT_W.
module srl_count_sel #(
    parameter int SEL_W = 8,
    parameter int CNT_W = 5
) (
    input  logic             use_imm,
    input  logic [SEL_W-1:0] cnt_reg,
    input  logic [SEL_W-1:0] cnt_imm,
    output logic [CNT_W-1:0] cnt_eff
);
    logic [SEL_W-1:0] picked;
    logic             unused_hi;

    // choose the source, then mask
    always_comb begin
        picked  = use_imm ? cnt_imm : cnt_reg;
        cnt_eff = picked[CNT_W-1:0];
    end

    assign unused_hi = ^picked[SEL_W-1:CNT_W];
endmodule

// File: rtl/srl_lane.sv
// Module: srl_lane
// Combinational shifter/rotator for one operand width W. It returns the
// shifted value and the last bit pushed out.
// Assumes: W is a power of two and W <= 2**CNT_W. A count of 0 is
// handled by the caller.
module srl_lane
    import srl_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 5
) (
    input  srl_op_e          op,
    input  logic [CNT_W-1:0] cnt,
    input  logic [W-1:0]     x,
    output logic [W-1:0]     res,
    output logic             cout
);
    localparam int RW = $clog2(W);

    logic               fill;
    logic signed [W+1:0] rsrc;
    logic signed [W+1:0] rsh;
    logic [W:0]          lsh;
    logic [RW-1:0]       rot;
    logic [W-1:0]        rol_v;
    logic [W-1:0]        ror_v;
    logic                unused_top;

    // right path: a guard bit below the word catches the last bit out
    always_comb begin
        fill = (op == OP_SAR) ? x[W-1] : 1'b0;
        rsrc = {fill, x, 1'b0};
        rsh  = rsrc >>> cnt;
    end

    // left path: a guard bit above the word catches the last bit out
    always_comb lsh = {1'b0, x} << cnt;

    // rotates wrap modulo the width
    always_comb begin
        rot   = cnt[RW-1:0];
        rol_v = (x << rot) | (x >> (W - int'(rot)));
        ror_v = (x >> rot) | (x << (W - int'(rot)));
    end

    // pick the result and carry for the operation
    always_comb begin
        case (op)
            OP_SHR, OP_SAR: begin res = rsh[W:1]; cout = rsh[0]; end
            OP_SHL, OP_SAL: begin res = lsh[W-1:0]; cout = lsh[W]; end
            OP_ROL:         begin res = rol_v; cout = rol_v[0]; end
            OP_ROR:         begin res = ror_v; cout = ror_v[W-1]; end
            default:        begin res = x; cout = 1'b0; end
        endcase
    end

    assign unused_top = rsh[W+1];

    // sign fill and zero fill guards
    always_comb begin
        if (!$isunknown({op, cnt, x}) && cnt != '0) begin
            // R2
            sar_fill_chk: assert (op != OP_SAR || res[W-1] == x[W-1]);
            // R2
            shr_fill_chk: assert (op != OP_SHR || res[W-1] == 1'b0);
        end
    end
endmodule

// File: rtl/srl_flag_merge.sv
// Module: srl_flag_merge
// Chooses the lane for the width, builds the 32-bit result and the flags,
// and applies pass-through for a zero count or a reserved opcode.
// Assumes: BYTE_W < DATA_W.
module srl_flag_merge #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              hold,
    input  logic              wide,
    input  logic [DATA_W-1:0] operand,
    input  logic [BYTE_W-1:0] res_byte,
    input  logic              c_byte,
    input  logic [DATA_W-1:0] res_word,
    input  logic              c_word,
    input  logic              zf_in,
    input  logic              sf_in,
    input  logic              cf_in,
    output logic [DATA_W-1:0] res_nxt,
    output logic              zf_nxt,
    output logic              sf_nxt,
    output logic              cf_nxt
);
    // width select, then pass-through override
    always_comb begin
        if (hold) begin
            res_nxt = operand;
            zf_nxt  = zf_in;
            sf_nxt  = sf_in;
            cf_nxt  = cf_in;
        end else if (wide) begin
            res_nxt = res_word;
            zf_nxt  = (res_word == '0);
            sf_nxt  = res_word[DATA_W-1];
            cf_nxt  = c_word;
        end else begin
            res_nxt = {operand[DATA_W-1:BYTE_W], res_byte};
            zf_nxt  = (res_byte == '0);
            sf_nxt  = res_byte[BYTE_W-1];
            cf_nxt  = c_byte;
        end
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Module: shift_rotate_unit (top)
// 8/32-bit shift and rotate with zero, sign and carry flags, one register
// stage of latency.
// Assumes: synchronous active-low reset, one request per cycle.
module shift_rotate_unit
    import srl_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic              wide,
    input  logic [DATA_W-1:0] operand,
    input  logic              cnt_sel,
    input  logic [SEL_W-1:0]  cnt_reg,
    input  logic [SEL_W-1:0]  cnt_imm,
    input  logic              zf_in,
    input  logic              sf_in,
    input  logic              cf_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              zf,
    output logic              sf,
    output logic              cf
);
    localparam int CNT_W = SRL_CNT_W;
    localparam int LANES = 2;

    srl_op_e           op_e;
    logic [CNT_W-1:0]  cnt_eff;
    logic [DATA_W-1:0] lane_res [LANES];
    logic              lane_c   [LANES];
    logic              hold;
    logic [DATA_W-1:0] res_nxt;
    logic              zf_nxt, sf_nxt, cf_nxt;

    assign op_e = srl_op_e'(op);

    srl_count_sel #(.SEL_W(SEL_W), .CNT_W(CNT_W)) i_cnt (
        .use_imm(cnt_sel), .cnt_reg(cnt_reg), .cnt_imm(cnt_imm), .cnt_eff(cnt_eff)
    );

    // lane 0 handles the byte width, lane 1 the word width
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? BYTE_W : DATA_W;
        logic [LW-1:0] r;
        logic          c;
        srl_lane #(.W(LW), .CNT_W(CNT_W)) i_lane (
            .op(op_e), .cnt(cnt_eff), .x(operand[LW-1:0]), .res(r), .cout(c)
        );
        assign lane_res[g] = DATA_W'(r);
        assign lane_c[g]   = c;
    end

    // zero count and reserved opcodes pass everything through
    assign hold = (cnt_eff == '0) || (op_e == OP_RSV6) || (op_e == OP_RSV7);

    logic unused_lane0;
    assign unused_lane0 = ^lane_res[0][DATA_W-1:BYTE_W];

    srl_flag_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_merge (
        .hold(hold), .wide(wide), .operand(operand),
        .res_byte(lane_res[0][BYTE_W-1:0]), .c_byte(lane_c[0]),
        .res_word(lane_res[1]), .c_word(lane_c[1]),
        .zf_in(zf_in), .sf_in(sf_in), .cf_in(cf_in),
        .res_nxt(res_nxt), .zf_nxt(zf_nxt), .sf_nxt(sf_nxt), .cf_nxt(cf_nxt)
    );

    // output register: load on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            zf        <= 1'b0;
            sf        <= 1'b0;
            cf        <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_nxt;
                zf     <= zf_nxt;
                sf     <= sf_nxt;
                cf     <= cf_nxt;
            end
        end
    end

    // R11
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(cf) && !out_valid);
    // R8
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !wide |=> result[DATA_W-1:BYTE_W] == $past(operand[DATA_W-1:BYTE_W]));
    // R9
    zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cnt_eff == '0 |=> result == $past(operand) && cf == $past(cf_in)
            && zf == $past(zf_in) && sf == $past(sf_in));
    // R12
    reset_clr_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid && result == '0);
endmodule

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  op;
    logic        wide;
    logic [31:0] operand;
    logic        cnt_sel;
    logic [7:0]  cnt_reg, cnt_imm;
    logic        zf_in, sf_in, cf_in;
    logic        out_valid;
    logic [31:0] result;
    logic        zf, sf, cf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shift_rotate_unit i_shift_rotate_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
        .operand(operand), .cnt_sel(cnt_sel), .cnt_reg(cnt_reg), .cnt_imm(cnt_imm),
        .zf_in(zf_in), .sf_in(sf_in), .cf_in(cf_in), .out_valid(out_valid),
        .result(result), .zf(zf), .sf(sf), .cf(cf)
    );

    // Reference: step one bit at a time; returns {result, zf, sf, cf}
    function automatic logic [34:0] model(input logic [2:0] o, input logic w,
                                          input logic [31:0] v, input int n,
                                          input logic zi, input logic si, input logic ci);
        int          bw = w ? 32 : 8;
        logic [31:0] mask = w ? 32'hFFFF_FFFF : 32'h0000_00FF;
        logic [31:0] x = v & mask;
        logic        c = ci;
        logic        top;
        logic [31:0] r;
        if (n == 0 || o > 3'd5) return {v, zi, si, ci};
        for (int i = 0; i < n; i++) begin
            case (o)
                3'd0: begin c = x[0]; x = x >> 1; end
                3'd1: begin c = x[0]; top = x[bw-1]; x = x >> 1; x[bw-1] = top; end
                3'd2, 3'd5: begin c = x[bw-1]; x = (x << 1) & mask; end
                3'd3: begin c = x[bw-1]; x = ((x << 1) | {31'd0, c}) & mask; end
                default: begin c = x[0]; x = (x >> 1); x[bw-1] = c; end
            endcase
        end
        r = w ? x : {v[31:8], x[7:0]};
        return {r, (x == 32'd0), x[bw-1], c};
    endfunction

    task automatic check(input string tag, input logic [34:0] got, input logic [34:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got res=%h z=%b s=%b c=%b exp res=%h z=%b s=%b c=%b",
                     tag, got[34:3], got[2], got[1], got[0], exp[34:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // drive one request after a falling edge, compare at the next falling edge
    task automatic run(input string tag, input logic [2:0] o, input logic w,
                       input logic [31:0] v, input logic s, input logic [7:0] cr,
                       input logic [7:0] ci8, input logic [2:0] fl);
        logic [34:0] exp;
        int n;
        in_valid = 1'b1; op = o; wide = w; operand = v; cnt_sel = s;
        cnt_reg = cr; cnt_imm = ci8; {zf_in, sf_in, cf_in} = fl;
        n = int'((s ? ci8 : cr) & 8'h1F);   // R1
        exp = model(o, w, v, n, fl[2], fl[1], fl[0]);
        @(negedge clk);
        check(tag, {result, zf, sf, cf}, exp);
        checks++;
        if (out_valid !== 1'b1) begin
            errors++;
            $display("FAIL R11 out_valid got %b exp 1", out_valid);
        end
    endtask

    string tag;
    initial begin
        logic [34:0] last;
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; op = 3'd0; wide = 1'b1; operand = 32'hDEAD_BEEF;
        cnt_sel = 1'b0; cnt_reg = 8'd0; cnt_imm = 8'd0; zf_in = 1'b1; sf_in = 1'b1; cf_in = 1'b1;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset", {result, zf, sf, cf}, 35'd0);
        checks++;
        if (out_valid !== 1'b0) begin errors++; $display("FAIL R12 out_valid got %b exp 0", out_valid); end
        rst_n = 1'b1;

        // R2 fills, R5 carry from low end with count 1
        run("R2 R5 shr word", 3'd0, 1'b1, 32'h8000_0003, 1'b1, 8'd9, 8'd1, 3'b000);
        check("R5 shr count1 carry=lsb", {35{1'b0}} | cf, 35'd1);
        run("R2 sar word", 3'd1, 1'b1, 32'h8000_0000, 1'b0, 8'd4, 8'd0, 3'b000);
        check("R2 sar fill", {3'd0, result}, {3'd0, 32'hF800_0000});
        run("R2 R5 sar byte past width", 3'd1, 1'b0, 32'h1234_5680, 1'b0, 8'd20, 8'd0, 3'b000);
        // R3 shl vs sal, R6 carry from top
        run("R3 R6 shl word", 3'd2, 1'b1, 32'h8000_0001, 1'b1, 8'd0, 8'd1, 3'b000);
        run("R3 sal word", 3'd5, 1'b1, 32'h8000_0001, 1'b1, 8'd0, 8'd1, 3'b000);
        run("R6 shl byte past width", 3'd2, 1'b0, 32'h0000_00FF, 1'b1, 8'd0, 8'd9, 3'b000);
        // R4 byte rotates wrap modulo 8
        run("R4 rol byte by 8", 3'd3, 1'b0, 32'hAA00_0081, 1'b0, 8'd8, 8'd0, 3'b000);
        run("R4 ror byte by 3", 3'd4, 1'b0, 32'h0000_0001, 1'b0, 8'd3, 8'd0, 3'b000);
        run("R4 rol word by 31", 3'd3, 1'b1, 32'h0000_0003, 1'b0, 8'd31, 8'd0, 3'b000);
        // R1 masking: 33 -> 1, and source select
        run("R1 mask 33", 3'd0, 1'b1, 32'h0000_0004, 1'b0, 8'd33, 8'd7, 3'b000);
        run("R1 imm sel", 3'd0, 1'b1, 32'h0000_0100, 1'b1, 8'd1, 8'd8, 3'b000);
        // R7 zero flag in byte mode with nonzero upper bits, R8 upper preserved
        run("R7 R8 byte zero", 3'd0, 1'b0, 32'hFFFF_FF01, 1'b0, 8'd1, 8'd0, 3'b010);
        // R9 zero count, R10 reserved codes
        run("R9 count 32", 3'd2, 1'b1, 32'h1357_9BDF, 1'b0, 8'd32, 8'd0, 3'b101);
        run("R10 op6", 3'd6, 1'b1, 32'h0F0F_0F0F, 1'b0, 8'd5, 8'd0, 3'b011);
        run("R10 op7", 3'd7, 1'b0, 32'hF0F0_F0F0, 1'b1, 8'd0, 8'd3, 3'b110);

        // R11 idle cycles hold outputs
        last = {result, zf, sf, cf};
        in_valid = 1'b0; operand = ~operand; op = 3'd2; cnt_reg = 8'd3; cnt_imm = 8'd3;
        @(negedge clk);
        check("R11 idle hold", {result, zf, sf, cf}, last);
        checks++;
        if (out_valid !== 1'b0) begin errors++; $display("FAIL R11 idle out_valid got %b exp 0", out_valid); end

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [2:0] o = 3'($urandom_range(0, 7));
            case (o)
                3'd0, 3'd1: tag = "R2 R5 R7 rand";
                3'd2, 3'd5: tag = "R3 R6 R7 rand";
                3'd3: tag = "R4 R6 rand";
                3'd4: tag = "R4 R5 rand";
                default: tag = "R10 rand";
            endcase
            run(tag, o, 1'($urandom), $urandom, 1'($urandom), 8'($urandom), 8'($urandom),
                3'($urandom));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule